// File: doc/BRIEF.md
# GPIO Edge Interrupt Controller

This block turns 32 general-purpose input pins into interrupt sources. Every pin is brought into the clock domain through a two-flop synchronizer. The synchronized level is then compared with its previous sample to find edges. For each pin, a per-pin control bit selects the qualifying edges: falling edges only, or both rising and falling edges. A qualifying edge sets a sticky event bit.

A per-pin mask decides which event bits can raise the single combined interrupt line. The event bit is set even while its pin is masked. To make servicing quick, the block also reports the number of one pending unmasked pin, together with a valid flag. Software reads and writes three word registers through a simple strobe bus. Event bits are acknowledged by writing ones to them.

Pin n always maps to bit (31 − n) of every register, so pin 0 is the most significant bit.

Top module: `gpio_edge_irq`

## Requirements
- R1: Pin n (0..31) occupies bit 31−n of the control, mask and event registers. Byte address 0x0 selects control, 0x4 selects mask and 0x8 selects event. A read strobe loads the addressed register into the read data on the same clock edge, so the value is visible from the following cycle.
- R2: After reset, the control, mask and event registers read zero, and the interrupt and pending-valid outputs are low.
- R3: When a pin's control bit is 1, a falling edge on that pin sets its event bit and a rising edge does not.
- R4: When a pin's control bit is 0, both rising and falling edges on that pin set its event bit.
- R5: Writing the event register clears each bit written as 1. Bits written as 0 are left as they were, and writing all ones clears every event.
- R6: If a qualifying edge and a write-one-to-clear hit the same event bit on the same clock edge, the bit ends up set.
- R7: A mask bit of 1 lets its pin's event drive the interrupt, and a bit of 0 blocks it. An event captured while its pin is masked stays pending and raises the interrupt as soon as the mask bit is written to 1. Writing the mask register replaces all of its bits.
- R8: The interrupt output is high exactly when the bitwise AND of event and mask is nonzero.
- R9: The pending index gives the highest-numbered pin whose event and mask bits are both set, which is the least significant set bit of event AND mask. The pending-valid flag is high exactly when such a pin exists.
- R10: A pin change made just before clock edge k shows up in the event register after edge k+2. The register contents present at reset never produce an event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 32 | Asynchronous pin levels, bit 31−n is pin n |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_addr | input | 4 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Combined interrupt |
| pend_idx | output | 5 | Number of the reported pending pin |
| pend_vld | output | 1 | Pending index is meaningful |

## Verification
The edge detection is driven with rising and falling transitions on two pins, one in each trigger mode. A rise that sets only the any-edge pin separates the two modes, and the following fall sets both. Mask patterns with one bit, two bits and the most significant bit set check that the interrupt is gated correctly and that the reported index chooses the highest-numbered pin rather than the lowest. Clear writes of zero, of a single bit and of all ones, plus a clear that lands in the same cycle as a new edge, separate correct write-one-to-clear from write-through and from clear-wins behaviour. A single-pin rise watched cycle by cycle confirms the synchronizer latency.

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
  parameter int NPINS = 32,
  parameter int AW    = 4,
  parameter int IW    = $clog2(NPINS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] pin_i,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [AW-1:0]    bus_addr,
  input  logic [NPINS-1:0] bus_wdata,
  output logic [NPINS-1:0] bus_rdata,
  output logic             irq_o,
  output logic [IW-1:0]    pend_idx,
  output logic             pend_vld
);
  localparam logic [AW-1:0] CTL_A = AW'(4'h0);
  localparam logic [AW-1:0] MSK_A = AW'(4'h4);
  localparam logic [AW-1:0] EVT_A = AW'(4'h8);

  logic [NPINS-1:0] s1, s2, prev;
  logic [NPINS-1:0] ctrl, mask, evt, hit, edge_det, clr;
  logic [2:0]       arm;
  logic             wr_ctl, wr_msk, wr_evt;

  assign wr_ctl = bus_wr && (bus_addr == CTL_A);
  assign wr_msk = bus_wr && (bus_addr == MSK_A);
  assign wr_evt = bus_wr && (bus_addr == EVT_A);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1   <= '0;
      s2   <= '0;
      prev <= '0;
      arm  <= '0;
    end else begin
      s1   <= pin_i;
      s2   <= s1;
      prev <= s2;
      arm  <= {arm[1:0], 1'b1};
    end
  end

  assign edge_det = arm[2] ? ((~s2 & prev) | (s2 & ~prev & ~ctrl)) : '0;
  assign clr      = wr_evt ? bus_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      mask <= '0;
      evt  <= '0;
    end else begin
      if (wr_ctl) ctrl <= bus_wdata;
      if (wr_msk) mask <= bus_wdata;
      evt <= (evt & ~clr) | edge_det;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_rd) begin
      case (bus_addr)
        CTL_A:   bus_rdata <= ctrl;
        MSK_A:   bus_rdata <= mask;
        EVT_A:   bus_rdata <= evt;
        default: bus_rdata <= '0;
      endcase
    end
  end

  assign hit   = evt & mask;
  assign irq_o = |hit;

  always_comb begin
    pend_idx = '0;
    pend_vld = 1'b0;
    for (int j = NPINS - 1; j >= 0; j--) begin
      if (hit[j]) begin
        pend_idx = IW'(NPINS - 1 - j);
        pend_vld = 1'b1;
      end
    end
  end

  // R3
  fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt & ~$past(evt) & $past(ctrl) & $past(s2 & ~prev)) == '0));

  // R10
  evt_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt & ~$past(evt) & ~($past(s2) ^ $past(prev))) == '0));

  // R5
  w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_evt) |-> ((evt & $past(bus_wdata) & ~$past(edge_det)) == '0));

  // R7
  mask_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_msk) |-> (mask == $past(bus_wdata)));

  // R8
  irq_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == pend_vld);

  // R9
  pend_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_vld |-> (evt[NPINS-1-int'(pend_idx)] && mask[NPINS-1-int'(pend_idx)]));
endmodule

// File: tb/test_gpio_edge_irq.sv
module test_gpio_edge_irq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] pin_i = '0;
  logic        bus_wr = 0, bus_rd = 0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, pend_vld;
  logic [4:0]  pend_idx;

  int total = 0, bad = 0;
  logic rd_pend = 0;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t sbq[$];

  gpio_edge_irq i_gpio_edge_irq (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .pend_idx(pend_idx), .pend_vld(pend_vld));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) rd_pend <= bus_rd;

  always @(negedge clk) begin
    if (rd_pend) begin
      item_t it;
      total++;
      if (sbq.size() == 0) begin
        bad++;
        $display("FAIL read with no expected item: actual=%h expected=none", bus_rdata);
      end else begin
        it = sbq.pop_front();
        if (bus_rdata !== it.exp) begin
          bad++;
          $display("FAIL %s: actual=%h expected=%h", it.tag, bus_rdata, it.exp);
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd_expect(input logic [3:0] a, input logic [31:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    sbq.push_back(it);
    @(negedge clk);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic pins(input logic [31:0] v);
    @(negedge clk);
    pin_i = v;
    repeat (3) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired (R1..): actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R2 reset state
    chk("R2 irq", {31'b0, irq_o}, 32'h0);
    chk("R2 pend_vld", {31'b0, pend_vld}, 32'h0);
    rd_expect(4'h0, 32'h0, "R2 ctrl reset");
    rd_expect(4'h4, 32'h0, "R2 mask reset");
    rd_expect(4'h8, 32'h0, "R2 event reset");

    // pin3 = bit28 falling only, pin5 = bit26 any edge
    wr(4'h0, 32'h1000_0000);
    rd_expect(4'h0, 32'h1000_0000, "R1 ctrl readback");

    pins(32'h1400_0000);
    rd_expect(4'h8, 32'h0400_0000, "R3 R4 rise sets any-edge pin only");
    chk("R7 masked event no irq", {31'b0, irq_o}, 32'h0);

    pins(32'h0000_0000);
    rd_expect(4'h8, 32'h1400_0000, "R3 R4 fall sets both");

    wr(4'h4, 32'h1000_0000);
    chk("R7 unmask raises irq", {31'b0, irq_o}, 32'h1);
    chk("R9 pend idx pin3", {27'b0, pend_idx}, 32'd3);
    rd_expect(4'h4, 32'h1000_0000, "R1 mask readback");

    wr(4'h4, 32'h1400_0000);
    chk("R9 pend idx highest pin 5", {27'b0, pend_idx}, 32'd5);
    chk("R9 pend_vld", {31'b0, pend_vld}, 32'h1);

    wr(4'h8, 32'h0000_0000);
    rd_expect(4'h8, 32'h1400_0000, "R5 write zero keeps events");
    wr(4'h8, 32'h0400_0000);
    rd_expect(4'h8, 32'h1000_0000, "R5 single bit clear");
    chk("R9 pend idx back to pin3", {27'b0, pend_idx}, 32'd3);

    wr(4'h8, 32'hFFFF_FFFF);
    rd_expect(4'h8, 32'h0, "R5 clear all");
    chk("R8 irq low after clear", {31'b0, irq_o}, 32'h0);
    chk("R9 pend_vld low", {31'b0, pend_vld}, 32'h0);

    // R6: rise on pin0 (bit31) lands on same edge as clear-all
    @(negedge clk);
    pin_i = 32'h8000_0000;
    @(negedge clk);
    @(negedge clk);
    bus_wr = 1; bus_addr = 4'h8; bus_wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    bus_wr = 0;
    rd_expect(4'h8, 32'h8000_0000, "R6 set wins over clear");
    chk("R7 pin0 still masked", {31'b0, irq_o}, 32'h0);
    wr(4'h4, 32'h9400_0000);
    chk("R1 pin0 is msb, pend idx 0", {27'b0, pend_idx}, 32'd0);
    chk("R8 irq with pin0", {31'b0, irq_o}, 32'h1);

    // R7 masking all pins
    wr(4'h4, 32'h0);
    chk("R7 mask all drops irq", {31'b0, irq_o}, 32'h0);
    wr(4'h8, 32'hFFFF_FFFF);

    // R10 latency on pin31 (bit0)
    wr(4'h4, 32'h0000_0001);
    @(negedge clk);
    pin_i = 32'h8000_0001;
    @(negedge clk);
    chk("R10 not after edge k", {31'b0, irq_o}, 32'h0);
    @(negedge clk);
    chk("R10 not after edge k+1", {31'b0, irq_o}, 32'h0);
    @(negedge clk);
    chk("R10 set after edge k+2", {31'b0, irq_o}, 32'h1);
    chk("R9 pend idx 31", {27'b0, pend_idx}, 32'd31);

    repeat (2) @(negedge clk);
    chk("R1 scoreboard drained", sbq.size(), 32'd0);
    finish_run();
  end
endmodule